// File: doc/BRIEF.md
# Program Store Upload Controller

This block decides how a small core with an 8-bit program counter fills its 256-word, 16-bit instruction SRAM. It has two modes. After a hard reset it is in upload mode. Words come in on a valid/ready stream, and each accepted word is written into the SRAM at the address held in the program counter. The counter then advances by one. The counter's own incrementer carry-out marks the end of the image. There is no separate upload counter and no address multiplexer: the program counter drives the SRAM address in both modes.

After the counter wraps to zero, the next accepted word is not stored. It is compared with a 16-bit running sum of every word accepted in the current pass. If the two agree, the block enters run mode. In run mode the fetched instruction and the register-writeback enable pass through to the pipeline, and the counter advances on the core's step pulse. While the block is not running, the pipeline sees a no-operation word and writeback is held off.

A running program can ask for a new image. It does this by writing an image number to a register whose value is visible on output pins. It then issues an overlay request carrying a start address. The counter jumps to that address and uploading starts again from there, so a nonzero start refills only the top of the SRAM. A checksum mismatch latches an error that only a hard reset clears.

Stream rules: `up_ready` is high only while the block expects an image word or the checksum word. A word transfers on a rising clock edge where `up_valid` and `up_ready` are both high. The source may hold `up_valid` low between words for any number of cycles. It must keep `up_data` stable while `up_valid` is high and `up_ready` is low.

Top module: `imem_upload_ctrl`

## Requirements
- R1: After hard reset (`rst_n` low), `imem_addr` is 0, `mode_run` is 0, `up_ready` is 1, `csum_err` is 0 and `ovl_num` is 0.
- R2: In upload mode, each transfer of an image word drives `imem_we` high, with `imem_wdata` equal to `up_data` and `imem_addr` equal to the program counter. The counter then rises by one. Exactly one SRAM write happens per transfer.
- R3: While `mode_run` is 0, `pipe_insn` equals the NOP code (parameter, default 16'h0000) and `wb_en_out` is 0. While `mode_run` is 1, `pipe_insn` equals `imem_rdata` and `wb_en_out` equals `wb_en_in`.
- R4: After the word written at address 255, the counter reads 0 and `up_ready` stays high. The next transfer is the checksum word, and it is not written to the SRAM.
- R5: The checksum is the sum modulo 2^16 of all image words accepted since upload mode was last entered. If the checksum word equals it, `mode_run` becomes 1 and `up_ready` becomes 0.
- R6: In run mode, a high `step` advances the counter by one, wrapping from 255 to 0. In upload mode, `step` has no effect.
- R7: In run mode, `ovl_go` loads the counter from `ovl_pc`, clears the running sum and returns the block to upload mode. Outside run mode, `ovl_go` has no effect.
- R8: An upload that starts at address A writes only addresses A to 255. Lower addresses keep their earlier contents.
- R9: `ovl_num` takes the value of `ovl_num_d` on a clock edge where `ovl_num_we` is high. It keeps that value across overlays and checksum errors.
- R10: On a checksum mismatch, `csum_err` becomes 1, `mode_run` stays 0, the counter stays 0 and `up_ready` goes low. All of this holds until hard reset, and further stream words, `step` and `ovl_go` are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous hard reset |
| up_valid | input | 1 | Upload stream word valid |
| up_ready | output | 1 | Block accepts an upload word |
| up_data | input | 16 | Upload stream word |
| imem_we | output | 1 | Instruction SRAM write enable |
| imem_addr | output | 8 | SRAM address, the program counter |
| imem_wdata | output | 16 | SRAM write data |
| imem_rdata | input | 16 | SRAM read data at `imem_addr` |
| pipe_insn | output | 16 | Instruction handed to the pipeline |
| wb_en_in | input | 1 | Writeback enable from the core |
| wb_en_out | output | 1 | Writeback enable, gated by mode |
| step | input | 1 | Advance the counter in run mode |
| ovl_go | input | 1 | Overlay request in run mode |
| ovl_pc | input | 8 | Start address for the overlay upload |
| ovl_num_we | input | 1 | Load the image-number register |
| ovl_num_d | input | 8 | New image number |
| ovl_num | output | 8 | Image number for external upload logic |
| mode_run | output | 1 | 1 in run mode, 0 in upload mode |
| csum_err | output | 1 | Sticky checksum-mismatch flag |

## Verification
The first image is a full 256-word upload with an affine data pattern and a correct checksum. Reading every address back in run mode shows that each word landed at its own address and that the carry-out ended the image exactly at 255. The second image is a partial overlay starting at 0xC0, using a different pattern and a different image number. It tells apart writes that stay in the upper range from writes that leak below it, and it shows the sum being cleared rather than carried over. The last image starts at 0xF0 and ends with a wrong checksum. It separates the sticky error path from the run path. Stray `step` and `ovl_go` pulses in the wrong mode check that each is ignored.

// File: rtl/iload_pkg.sv
package iload_pkg;
  typedef enum logic [1:0] {
    ST_LOAD  = 2'd0,
    ST_CHECK = 2'd1,
    ST_RUN   = 2'd2,
    ST_FAIL  = 2'd3
  } iload_state_e;
endpackage

// File: rtl/iload_pc.sv
// Program counter with incrementer; the carry-out flags the wrap to zero.
module iload_pc #(
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          inc,
  input  logic          load,
  input  logic [AW-1:0] load_val,
  output logic [AW-1:0] pc,
  output logic          wrap
);
  logic [AW:0] inc_res;

  assign inc_res = {1'b0, pc} + {{AW{1'b0}}, 1'b1};
  assign wrap    = inc & inc_res[AW];

  always_ff @(posedge clk) begin
    if (!rst_n)    pc <= '0;
    else if (load) pc <= load_val;
    else if (inc)  pc <= inc_res[AW-1:0];
  end
endmodule

// File: rtl/iload_csum.sv
// Running 16-bit additive checksum over the words of one upload pass.
module iload_csum #(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          add,
  input  logic [DW-1:0] word,
  output logic [DW-1:0] sum
);
  always_ff @(posedge clk) begin
    if (!rst_n || clr) sum <= '0;
    else if (add)      sum <= sum + word;
  end
endmodule

// File: rtl/iload_fsm.sv
// Mode sequencer: image load, checksum compare, run, sticky failure.
module iload_fsm
  import iload_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic xfer,
  input  logic wrap,
  input  logic match,
  input  logic ovl_go,
  output logic ready,
  output logic we,
  output logic run,
  output logic fail,
  output logic ovl_take
);
  iload_state_e state, state_nxt;

  assign ready    = (state == ST_LOAD) || (state == ST_CHECK);
  assign we       = xfer && (state == ST_LOAD);
  assign run      = (state == ST_RUN);
  assign fail     = (state == ST_FAIL);
  assign ovl_take = run && ovl_go;

  always_comb begin
    state_nxt = state;
    unique case (state)
      ST_LOAD:  if (xfer && wrap) state_nxt = ST_CHECK;
      ST_CHECK: if (xfer)         state_nxt = match ? ST_RUN : ST_FAIL;
      ST_RUN:   if (ovl_go)       state_nxt = ST_LOAD;
      ST_FAIL:                    state_nxt = ST_FAIL;
      default:                    state_nxt = ST_LOAD;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) state <= ST_LOAD;
    else        state <= state_nxt;
  end
endmodule

// File: rtl/imem_upload_ctrl.sv
module imem_upload_ctrl #(
  parameter int          AW  = 8,
  parameter int          DW  = 16,
  parameter int          ONW = 8,
  parameter logic [15:0] NOP = 16'h0000
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           up_valid,
  output logic           up_ready,
  input  logic [DW-1:0]  up_data,
  output logic           imem_we,
  output logic [AW-1:0]  imem_addr,
  output logic [DW-1:0]  imem_wdata,
  input  logic [DW-1:0]  imem_rdata,
  output logic [DW-1:0]  pipe_insn,
  input  logic           wb_en_in,
  output logic           wb_en_out,
  input  logic           step,
  input  logic           ovl_go,
  input  logic [AW-1:0]  ovl_pc,
  input  logic           ovl_num_we,
  input  logic [ONW-1:0] ovl_num_d,
  output logic [ONW-1:0] ovl_num,
  output logic           mode_run,
  output logic           csum_err
);
  localparam logic [DW-1:0] NOP_W = DW'(NOP);

  logic          xfer, wr, run, fail, ovl_take, wrap, match, pc_inc;
  logic [AW-1:0] pc;
  logic [DW-1:0] sum;

  assign xfer   = up_valid && up_ready;
  assign match  = (up_data == sum);
  assign pc_inc = wr || (run && step && !ovl_go);

  iload_fsm u_fsm (
    .clk      (clk),
    .rst_n    (rst_n),
    .xfer     (xfer),
    .wrap     (wrap),
    .match    (match),
    .ovl_go   (ovl_go),
    .ready    (up_ready),
    .we       (wr),
    .run      (run),
    .fail     (fail),
    .ovl_take (ovl_take)
  );

  iload_pc #(.AW(AW)) u_pc (
    .clk      (clk),
    .rst_n    (rst_n),
    .inc      (pc_inc),
    .load     (ovl_take),
    .load_val (ovl_pc),
    .pc       (pc),
    .wrap     (wrap)
  );

  iload_csum #(.DW(DW)) u_csum (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (ovl_take),
    .add   (wr),
    .word  (up_data),
    .sum   (sum)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)          ovl_num <= '0;
    else if (ovl_num_we) ovl_num <= ovl_num_d;
  end

  assign imem_we    = wr;
  assign imem_addr  = pc;
  assign imem_wdata = up_data;
  assign pipe_insn  = run ? imem_rdata : NOP_W;
  assign wb_en_out  = run && wb_en_in;
  assign mode_run   = run;
  assign csum_err   = fail;
endmodule

// File: rtl/imem_upload_ctrl_chk.sv
module imem_upload_ctrl_chk #(
  parameter int          AW  = 8,
  parameter int          DW  = 16,
  parameter logic [15:0] NOP = 16'h0000
) (
  input logic          clk,
  input logic          rst_n,
  input logic          up_ready,
  input logic          imem_we,
  input logic [AW-1:0] imem_addr,
  input logic [DW-1:0] pipe_insn,
  input logic          wb_en_out,
  input logic          ovl_go,
  input logic [AW-1:0] ovl_pc,
  input logic          mode_run,
  input logic          csum_err
);
  AST_WE_NOT_IN_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    imem_we |-> !mode_run && !csum_err); // R2
  AST_ADDR_STEPS_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    imem_we |=> imem_addr == AW'($past(imem_addr) + 1'b1)); // R2
  AST_IDLE_PIPE: assert property (@(posedge clk) disable iff (!rst_n)
    !mode_run |-> (pipe_insn == DW'(NOP)) && !wb_en_out); // R3
  AST_NO_READY_IN_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    mode_run |-> !up_ready); // R5
  AST_RUN_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    mode_run && !ovl_go |=> mode_run); // R5
  AST_OVERLAY_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    mode_run && ovl_go |=> !mode_run && up_ready && imem_addr == $past(ovl_pc)); // R7
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    csum_err |=> csum_err && !up_ready && !mode_run && imem_addr == '0); // R10
endmodule

bind imem_upload_ctrl imem_upload_ctrl_chk #(.AW(AW), .DW(DW), .NOP(NOP)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .up_ready  (up_ready),
  .imem_we   (imem_we),
  .imem_addr (imem_addr),
  .pipe_insn (pipe_insn),
  .wb_en_out (wb_en_out),
  .ovl_go    (ovl_go),
  .ovl_pc    (ovl_pc),
  .mode_run  (mode_run),
  .csum_err  (csum_err)
);

// File: tb/imem_upload_ctrl_test.sv
`timescale 1ns/1ps
module imem_upload_ctrl_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        up_valid, up_ready, imem_we, wb_en_in, wb_en_out, step, ovl_go;
  logic        ovl_num_we, mode_run, csum_err;
  logic [15:0] up_data, imem_wdata, imem_rdata, pipe_insn;
  logic [7:0]  imem_addr, ovl_pc, ovl_num_d, ovl_num;

  logic [15:0] mem [256];
  logic [15:0] expv [256];
  int          n_wr = 0;
  int          n_chk = 0;
  int          n_fail = 0;

  always #4 clk = ~clk;

  imem_upload_ctrl uut (
    .clk(clk), .rst_n(rst_n), .up_valid(up_valid), .up_ready(up_ready),
    .up_data(up_data), .imem_we(imem_we), .imem_addr(imem_addr),
    .imem_wdata(imem_wdata), .imem_rdata(imem_rdata), .pipe_insn(pipe_insn),
    .wb_en_in(wb_en_in), .wb_en_out(wb_en_out), .step(step), .ovl_go(ovl_go),
    .ovl_pc(ovl_pc), .ovl_num_we(ovl_num_we), .ovl_num_d(ovl_num_d),
    .ovl_num(ovl_num), .mode_run(mode_run), .csum_err(csum_err)
  );

  // SRAM model driven by the block's write port
  always @(posedge clk) begin
    if (imem_we) begin
      mem[imem_addr] <= imem_wdata;
      n_wr <= n_wr + 1;
    end
  end
  assign imem_rdata = mem[imem_addr];

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int expd);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, expd);
    end
  endtask

  task automatic send_word(input logic [15:0] d);
    @(negedge clk);
    up_valid = 1'b1;
    up_data  = d;
    while (!up_ready) @(negedge clk);
    @(negedge clk);
    up_valid = 1'b0;
  endtask

  task automatic pulse_ovl(input logic [7:0] start);
    @(negedge clk);
    ovl_go = 1'b1;
    ovl_pc = start;
    @(negedge clk);
    ovl_go = 1'b0;
  endtask

  task automatic pulse_step();
    @(negedge clk);
    step = 1'b1;
    @(negedge clk);
    step = 1'b0;
  endtask

  // Upload image words from 'start' to 255, then the checksum word
  task automatic upload(input int start, input int mul, input int add,
                        input bit bad, output int writes);
    logic [15:0] s = 16'h0;
    int w0 = n_wr;
    for (int i = start; i < 256; i++) begin
      logic [15:0] v = 16'(i * mul + add);
      chk(imem_addr == 8'(i), "R2", "address before word", imem_addr, i);
      expv[i] = v;
      s = s + v;
      send_word(v);
    end
    chk(imem_addr == 8'h00 && up_ready && !mode_run, "R4",
        "wrap then wait for checksum", imem_addr, 0);
    writes = n_wr - w0;
    send_word(bad ? (s ^ 16'h0001) : s);
    chk(n_wr - w0 == writes, "R4", "checksum word not stored", n_wr - w0, writes);
  endtask

  task automatic sweep(input string req);
    int bad = 0;
    for (int i = 0; i < 256; i++) begin
      if (imem_addr != 8'(i) || pipe_insn != expv[i]) bad++;
      pulse_step();
    end
    chk(bad == 0, req, "readback mismatches", bad, 0);
    chk(imem_addr == 8'h00, "R6", "step wraps 255 to 0", imem_addr, 0);
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(imem_addr == 0 && !mode_run && up_ready && !csum_err && ovl_num == 0,
        "R1", "reset state", {imem_addr, 7'd0, mode_run}, 0);
    chk(pipe_insn == 16'h0000 && !wb_en_out, "R3", "NOP while uploading",
        pipe_insn, 0);
    pulse_step();
    chk(imem_addr == 0, "R6", "step ignored in upload", imem_addr, 0);
    pulse_ovl(8'h05);
    chk(imem_addr == 0 && up_ready, "R7", "ovl_go ignored in upload", imem_addr, 0);
  endtask

  task automatic t_full();
    int w;
    upload(0, 37, 5, 1'b0, w);
    chk(w == 256, "R2", "one write per word", w, 256);
    @(negedge clk);
    chk(mode_run && !up_ready && !csum_err, "R5", "good checksum enters run",
        mode_run, 1);
    chk(wb_en_out == 1'b1, "R3", "writeback passes in run", wb_en_out, 1);
    sweep("R2");
  endtask

  task automatic t_partial();
    int w;
    @(negedge clk);
    ovl_num_we = 1'b1;
    ovl_num_d  = 8'h03;
    @(negedge clk);
    ovl_num_we = 1'b0;
    chk(ovl_num == 8'h03, "R9", "image number loaded", ovl_num, 3);
    pulse_ovl(8'hC0);
    chk(!mode_run && up_ready && imem_addr == 8'hC0, "R7", "overlay start address",
        imem_addr, 8'hC0);
    chk(pipe_insn == 16'h0000 && !wb_en_out, "R3", "NOP during overlay", pipe_insn, 0);
    upload(8'hC0, 91, 16'h4000, 1'b0, w);
    chk(w == 64, "R8", "writes limited to top range", w, 64);
    @(negedge clk);
    chk(mode_run, "R5", "partial checksum without old sum", mode_run, 1);
    sweep("R8");
    chk(ovl_num == 8'h03, "R9", "image number kept", ovl_num, 3);
  endtask

  task automatic t_bad();
    int w;
    int w0;
    pulse_ovl(8'hF0);
    upload(8'hF0, 7, 1, 1'b1, w);
    @(negedge clk);
    chk(csum_err && !mode_run && !up_ready && imem_addr == 0, "R10",
        "mismatch latches error", csum_err, 1);
    w0 = n_wr;
    up_valid = 1'b1;
    up_data  = 16'hBEEF;
    repeat (4) @(negedge clk);
    up_valid = 1'b0;
    pulse_step();
    pulse_ovl(8'h10);
    chk(n_wr == w0 && imem_addr == 0 && csum_err, "R10", "inputs ignored after error",
        n_wr - w0, 0);
    chk(ovl_num == 8'h03, "R9", "image number kept on error", ovl_num, 3);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!csum_err && up_ready && ovl_num == 0, "R1", "hard reset clears error",
        csum_err, 0);
  endtask

  initial begin
    rst_n = 1'b0; up_valid = 1'b0; up_data = '0; wb_en_in = 1'b1; step = 1'b0;
    ovl_go = 1'b0; ovl_pc = '0; ovl_num_we = 1'b0; ovl_num_d = '0;
    for (int i = 0; i < 256; i++) mem[i] = 16'hFFFF;
    t_reset();
    t_full();
    t_partial();
    t_bad();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule